// File: doc/BRIEF.md
# Rate-Trimmed Synchronized Timebase

This block keeps a local copy of master time whose tick rate can be trimmed in small fractional steps. A phase accumulator adds a rate word on every oscillator cycle. Each carry out of the accumulator advances a wide time counter by one tick. With a 50 MHz oscillator and the reset rate word, the counter runs at a nominal 40 MHz, because the tick rate is f_osc × rate / 2^ACC_W.

Software writes an offset and a propagation delay into holding registers. The offset is added to the local count to form the local copy of master time. Each time a synchronization frame arrives, the master's reference time is presented together with a one-cycle strobe. The block then measures the drift, which is the local copy minus the delay-corrected reference. It corrects the rate word using the change in drift since the previous frame, damped by a right shift. It also keeps a running mean of the last eight drift samples, which the master can poll to judge whether synchronization has settled.

Top module: `rate_trim_timebase`

## Requirements
- R1: While reset is high and on the first cycle after it, rate_word is 0xCCCCCCCD. local_time, master_time, drift and drift_mean are all zero.
- R2: On every clock, the accumulator adds rate_word modulo 2^32. A carry from that addition makes local_time increase by exactly one on the following clock. local_time never increases by more than one per clock.
- R3: offset_wr loads offset_val into the offset register. master_time equals local_time plus the offset register, delayed by one clock.
- R4: A clock with sync_stb high loads drift with master_time − (ref_time + delay register) as a signed 64-bit value. delay_wr loads delay_val into the delay register. The new drift is visible after that edge.
- R5: One clock after a strobe, rate_word becomes rate_word − floor((drift − previous drift) / 32), and the previous drift takes the current drift. The previous drift is zero after reset. A rising drift therefore lowers the rate, and a falling drift raises it.
- R6: The rate update saturates: a result below zero gives 0x00000000, and a result above 2^32−1 gives 0xFFFFFFFF.
- R7: Two clocks after a strobe, drift_mean equals floor(sum of the last eight drift samples / 8). Slots that have not yet been filled since reset count as zero.
- R8: Without a strobe, rate_word, drift and drift_mean hold their values.
- R9: While rate_word stays zero, local_time stops advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_stb | input | 1 | One-cycle strobe: a synchronization frame has arrived |
| ref_time | input | 64 | Master reference time carried by the frame |
| offset_wr | input | 1 | Write enable for the offset register |
| offset_val | input | 64 | Offset value to load |
| delay_wr | input | 1 | Write enable for the delay register |
| delay_val | input | 64 | Propagation delay value to load |
| local_time | output | 64 | Raw tick counter |
| master_time | output | 64 | Local copy of master time (count plus offset) |
| rate_word | output | 32 | Current compensating rate word |
| drift | output | 64 | Last measured drift, signed |
| drift_mean | output | 64 | Mean of the last eight drifts, signed |

## Verification
The update path is driven with a sequence of drifts that covers several cases. A first positive drift against a zero history checks the reset value of the previous drift. A repeated drift must leave the rate unchanged, because only the change in drift counts. Swings of either sign check the direction of the correction and the floor rounding of negative shifts. A ninth and later sample shows the mean ring dropping its oldest entry. Extreme drifts of ±2^40 drive the rate into both saturation bounds. The zero rate that results is then used to confirm that the counter freezes. The tick counter is compared on every cycle against an independent accumulator model, so any phase or carry-timing error separates from a simple rate error.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  // Rate word that yields f_out from f_osc with an acc_w-bit accumulator, rounded up.
  function automatic logic [63:0] nominal_rate(input logic [63:0] f_osc,
                                               input logic [63:0] f_out,
                                               input int unsigned acc_w);
    return ((f_out << acc_w) + f_osc - 64'd1) / f_osc;
  endfunction

endpackage

// File: rtl/rtt_phase_accum.sv
module rtt_phase_accum #(
  parameter int ACC_W  = 32,
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  rate,
  output logic [TIME_W-1:0] ticks
);
  logic [ACC_W-1:0] acc_q;
  logic             carry_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w = {1'b0, acc_q} + {1'b0, rate};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
      ticks   <= '0;
    end else begin
      acc_q   <= sum_w[ACC_W-1:0];
      carry_q <= sum_w[ACC_W];
      ticks   <= ticks + {{(TIME_W-1){1'b0}}, carry_q};
    end
  end
endmodule

// File: rtl/rtt_drift_loop.sv
module rtt_drift_loop #(
  parameter int              ACC_W     = 32,
  parameter int              TIME_W    = 64,
  parameter int              DAMP_SH   = 5,
  parameter logic [ACC_W-1:0] RATE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_stb,
  input  logic [TIME_W-1:0] ref_time,
  input  logic [TIME_W-1:0] delay,
  input  logic [TIME_W-1:0] master_time,
  output logic [TIME_W-1:0] drift_q,
  output logic [TIME_W-1:0] prev_q,
  output logic              upd_q,
  output logic [ACC_W-1:0]  rate_q
);
  localparam int CW     = ((ACC_W > TIME_W) ? ACC_W : TIME_W) + 3;
  localparam int STEP_W = TIME_W + 1 - DAMP_SH;

  logic [TIME_W-1:0]        drift_w;
  logic signed [TIME_W:0]   diff_w;
  logic signed [STEP_W-1:0] step_w;
  logic signed [CW-1:0]     rate_x, step_x, cand_w;
  logic [ACC_W-1:0]         rate_nx;

  assign drift_w = master_time - ref_time - delay;
  assign diff_w  = $signed({drift_q[TIME_W-1], drift_q}) - $signed({prev_q[TIME_W-1], prev_q});
  // slicing off the low bits is an arithmetic shift that rounds toward minus infinity
  assign step_w  = diff_w[TIME_W:DAMP_SH];
  assign rate_x  = $signed({{(CW-ACC_W){1'b0}}, rate_q});
  assign step_x  = $signed({{(CW-STEP_W){step_w[STEP_W-1]}}, step_w});
  assign cand_w  = rate_x - step_x;

  always_comb begin
    if (cand_w[CW-1])              rate_nx = '0;
    else if (|cand_w[CW-2:ACC_W])  rate_nx = '1;
    else                           rate_nx = cand_w[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drift_q <= '0;
      prev_q  <= '0;
      upd_q   <= 1'b0;
      rate_q  <= RATE_INIT;
    end else begin
      upd_q <= sync_stb;
      if (sync_stb) drift_q <= drift_w;
      if (upd_q) begin
        rate_q <= rate_nx;
        prev_q <= drift_q;
      end
    end
  end
endmodule

// File: rtl/rtt_drift_avg.sv
module rtt_drift_avg #(
  parameter int TIME_W     = 64,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [TIME_W-1:0] sample,
  output logic [TIME_W-1:0] mean_q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int SUM_W = TIME_W + DEPTH_LOG2;

  logic [TIME_W-1:0]     ring [DEPTH];
  logic [DEPTH_LOG2-1:0] wp_q;
  logic [DEPTH-1:0]      filled_q;
  logic signed [SUM_W-1:0] sum_q, in_x, out_x;
  logic [TIME_W-1:0]     oldest_w;

  assign oldest_w = filled_q[wp_q] ? ring[wp_q] : '0;
  assign in_x     = $signed({{DEPTH_LOG2{sample[TIME_W-1]}}, sample});
  assign out_x    = $signed({{DEPTH_LOG2{oldest_w[TIME_W-1]}}, oldest_w});

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) ring[wp_q] <= sample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      filled_q <= '0;
      sum_q    <= '0;
      mean_q   <= '0;
    end else begin
      if (push) begin
        sum_q          <= sum_q + in_x - out_x;
        filled_q[wp_q] <= 1'b1;
        wp_q           <= wp_q + 1'b1;
      end
      mean_q <= sum_q[SUM_W-1:DEPTH_LOG2];
    end
  end
endmodule

// File: rtl/rate_trim_timebase.sv
module rate_trim_timebase #(
  parameter int          ACC_W      = 32,
  parameter int          TIME_W     = 64,
  parameter int          DAMP_SH    = 5,
  parameter int          MEAN_LOG2  = 3,
  parameter logic [63:0] F_OSC_HZ   = 64'd50_000_000,
  parameter logic [63:0] F_OUT_HZ   = 64'd40_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_stb,
  input  logic [TIME_W-1:0] ref_time,
  input  logic              offset_wr,
  input  logic [TIME_W-1:0] offset_val,
  input  logic              delay_wr,
  input  logic [TIME_W-1:0] delay_val,
  output logic [TIME_W-1:0] local_time,
  output logic [TIME_W-1:0] master_time,
  output logic [ACC_W-1:0]  rate_word,
  output logic [TIME_W-1:0] drift,
  output logic [TIME_W-1:0] drift_mean
);
  localparam logic [ACC_W-1:0] RATE_INIT =
    ACC_W'(rtt_pkg::nominal_rate(F_OSC_HZ, F_OUT_HZ, ACC_W));

  logic [TIME_W-1:0] offset_q, delay_q, prev_drift;
  logic              upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q    <= '0;
      delay_q     <= '0;
      master_time <= '0;
    end else begin
      if (offset_wr) offset_q <= offset_val;
      if (delay_wr)  delay_q  <= delay_val;
      master_time <= local_time + offset_q;
    end
  end

  rtt_phase_accum #(.ACC_W(ACC_W), .TIME_W(TIME_W)) u_accum (
    .clk(clk), .rst(rst), .rate(rate_word), .ticks(local_time)
  );

  rtt_drift_loop #(.ACC_W(ACC_W), .TIME_W(TIME_W), .DAMP_SH(DAMP_SH),
                   .RATE_INIT(RATE_INIT)) u_loop (
    .clk(clk), .rst(rst), .sync_stb(sync_stb), .ref_time(ref_time),
    .delay(delay_q), .master_time(master_time), .drift_q(drift),
    .prev_q(prev_drift), .upd_q(upd_q), .rate_q(rate_word)
  );

  rtt_drift_avg #(.TIME_W(TIME_W), .DEPTH_LOG2(MEAN_LOG2)) u_avg (
    .clk(clk), .rst(rst), .push(upd_q), .sample(drift), .mean_q(drift_mean)
  );
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int              ACC_W     = 32,
  parameter int              TIME_W    = 64,
  parameter logic [ACC_W-1:0] RATE_INIT = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_stb,
  input logic              upd,
  input logic [TIME_W-1:0] local_time,
  input logic [ACC_W-1:0]  rate_word,
  input logic [TIME_W-1:0] drift,
  input logic [TIME_W-1:0] prev
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rate_word == RATE_INIT && local_time == '0));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (local_time == $past(local_time)) || (local_time == $past(local_time) + 1'b1));

  a_r5_rise_slows: assert property (@(posedge clk) disable iff (rst)
    (upd && ($signed(drift) > $signed(prev))) |=> rate_word <= $past(rate_word));

  a_r5_fall_speeds: assert property (@(posedge clk) disable iff (rst)
    (upd && ($signed(drift) < $signed(prev))) |=> rate_word >= $past(rate_word));

  a_r8_drift_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_stb |=> $stable(drift));

  a_r8_rate_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_stb |=> ##1 $stable(rate_word));

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (rate_word == '0 && $past(rate_word) == '0) |=> $stable(local_time));
endmodule

bind rate_trim_timebase rtt_checker #(.ACC_W(ACC_W), .TIME_W(TIME_W), .RATE_INIT(RATE_INIT)) u_chk (
  .clk(clk), .rst(rst), .sync_stb(sync_stb), .upd(upd_q), .local_time(local_time),
  .rate_word(rate_word), .drift(drift), .prev(prev_drift)
);

// File: tb/rate_trim_timebase_bench.sv
module rate_trim_timebase_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_stb = 1'b0, offset_wr = 1'b0, delay_wr = 1'b0;
  logic [63:0] ref_time = '0, offset_val = '0, delay_val = '0;
  logic [63:0] local_time, master_time, drift, drift_mean;
  logic [31:0] rate_word;

  int n_chk = 0, n_bad = 0, mism = 0;

  localparam int VEC_N = 11;
  localparam logic [63:0] T_DRIFT [VEC_N] = '{64'd320, 64'd320, -64'sd640, 64'd0, 64'd64, 64'd64,
                                              64'd64, 64'd64, -64'sd100, -64'sd100, 64'd33};
  localparam logic [31:0] T_RATE [VEC_N] = '{32'hCCCCCCC3, 32'hCCCCCCC3, 32'hCCCCCCE1, 32'hCCCCCCCD,
                                             32'hCCCCCCCB, 32'hCCCCCCCB, 32'hCCCCCCCB, 32'hCCCCCCCB,
                                             32'hCCCCCCD1, 32'hCCCCCCD1, 32'hCCCCCCCD};
  localparam logic [63:0] T_MEAN [VEC_N] = '{64'd40, 64'd80, 64'd0, 64'd0, 64'd8, 64'd16, 64'd24,
                                             64'd32, -64'sd21, -64'sd73, 64'd11};
  localparam logic [63:0] DELAY = 64'd50;

  always #2 clk = ~clk;

  rate_trim_timebase u_rate_trim_timebase (
    .clk(clk), .rst(rst), .sync_stb(sync_stb), .ref_time(ref_time),
    .offset_wr(offset_wr), .offset_val(offset_val), .delay_wr(delay_wr), .delay_val(delay_val),
    .local_time(local_time), .master_time(master_time), .rate_word(rate_word),
    .drift(drift), .drift_mean(drift_mean)
  );

  // independent accumulator model (R2), sampled 1 ns after each rising edge
  logic [31:0] m_acc = '0, m_rate = '0;
  logic        m_c = 1'b0;
  logic [63:0] m_t = '0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      m_acc = '0; m_c = 1'b0; m_t = '0;
    end else begin
      logic [63:0] nt;
      nt = m_t + {63'd0, m_c};
      {m_c, m_acc} = {1'b0, m_acc} + {1'b0, m_rate};
      m_t = nt;
      if (m_t !== local_time) mism++;
    end
    m_rate = rate_word;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [63:0] d);
    ref_time = master_time - DELAY - d;
    sync_stb = 1'b1;
    @(negedge clk);
    sync_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] lt, r_s, d_s, m_s;
    repeat (3) @(negedge clk);
    chk(rate_word == 32'hCCCCCCCD, "R1 rate", {32'd0, rate_word}, 64'hCCCCCCCD);
    chk(local_time == 0 && master_time == 0, "R1 times", local_time | master_time, 64'd0);
    chk(drift == 0 && drift_mean == 0, "R1 drift/mean", drift | drift_mean, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rate_word == 32'hCCCCCCCD, "R1 rate after release", {32'd0, rate_word}, 64'hCCCCCCCD);
    repeat (200) @(negedge clk);
    chk(local_time >= 64'd158 && local_time <= 64'd161, "R2 nominal 0.8 tick rate", local_time, 64'd159);

    // R3 offset
    offset_val = 64'd1000; offset_wr = 1'b1;
    @(negedge clk); offset_wr = 1'b0;
    @(negedge clk); lt = local_time;
    @(negedge clk);
    chk(master_time == lt + 64'd1000, "R3 master=local+offset", master_time, lt + 64'd1000);

    delay_val = DELAY; delay_wr = 1'b1;
    @(negedge clk); delay_wr = 1'b0;
    @(negedge clk);

    // table walk: R4 drift, R5 damped rate update, R7 eight-sample mean
    for (int i = 0; i < VEC_N; i++) begin
      strobe(T_DRIFT[i]);
      chk(drift == T_DRIFT[i], $sformatf("R4 drift vec %0d", i), drift, T_DRIFT[i]);
      @(negedge clk);
      chk(rate_word == T_RATE[i], $sformatf("R5 rate vec %0d", i), {32'd0, rate_word}, {32'd0, T_RATE[i]});
      @(negedge clk);
      chk(drift_mean == T_MEAN[i], $sformatf("R7 mean vec %0d", i), drift_mean, T_MEAN[i]);
      @(negedge clk);
    end

    // R8 idle: nothing moves without a strobe even if ref_time changes
    r_s = {32'd0, rate_word}; d_s = drift; m_s = drift_mean;
    for (int k = 0; k < 30; k++) begin
      ref_time = ref_time + 64'd12345;
      @(negedge clk);
    end
    chk({32'd0, rate_word} == r_s, "R8 rate held", {32'd0, rate_word}, r_s);
    chk(drift == d_s && drift_mean == m_s, "R8 drift/mean held", drift ^ d_s, m_s ^ drift_mean);

    // R6 saturation both ways
    strobe(-64'sd1099511627776);
    @(negedge clk);
    chk(rate_word == 32'hFFFFFFFF, "R6 saturate high", {32'd0, rate_word}, 64'hFFFFFFFF);
    @(negedge clk);
    strobe(64'd1099511627776);
    @(negedge clk);
    chk(rate_word == 32'h0, "R6 saturate low", {32'd0, rate_word}, 64'd0);

    // R9 zero rate freezes the counter
    repeat (3) @(negedge clk);
    lt = local_time;
    repeat (20) @(negedge clk);
    chk(local_time == lt, "R9 counter frozen", local_time, lt);

    chk(mism == 0, "R2 cycle-exact accumulator model", mism, 64'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule